// File: doc/BRIEF.md
# Serial-Loaded Configuration Latch Bank

This block receives configuration words over a three-wire serial link made of a data line, a serial clock and a load strobe. Each rising edge of the serial clock pushes one data bit into an 18-bit shift register, most significant bit first. The last two bits of a word are an address. When the load strobe rises, the other 16 bits of the word are copied into the one configuration latch, of four, that the address selects. The four latched payloads are presented in parallel to the synthesizer logic downstream.

All three serial lines are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its edges are then found by comparing it with its value one system clock earlier. Two hardware enable inputs are also synchronized, one for the main synthesizer section and one for the auxiliary section. They are presented as per-section enable outputs that gate those sections. They are independent of the serial registers. Each latch has a one-cycle update strobe, so downstream logic can take up a new setting at once.

Top module: `serial_latch_bank`

## Requirements
- R1: After reset, the shift register, all four latches and all strobes are zero.
- R2: Each synchronized rising edge of serClk shifts the synchronized serData into bit 0 of the shift register, so a word is sent MSB first. Only the last 18 bits shifted in are kept; earlier bits fall off the top.
- R3: On a rising edge of serLoad, bits [1:0] of the shift register (the last two bits sent) give a latch index from 0 to 3. Bits [17:2] are stored in that latch, which appears on latchData[16*i +: 16] for latch i.
- R4: A load leaves the payload of the three latches it does not address unchanged.
- R5: The update of latch i raises latchStrobe[i] for exactly one system clock. At most one strobe bit is high at any time, and no strobe rises without a load.
- R6: Only a rising edge of serLoad updates a latch. Holding serLoad high causes no further update. Serial clock edges while serLoad is high still shift data, and the next rising edge of serLoad loads that data.
- R7: mainEnOut and auxEnOut follow mainEnIn and auxEnIn, each independently, two system clocks after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial bit clock, asynchronous |
| serData | input | 1 | Serial data bit, MSB first |
| serLoad | input | 1 | Load strobe; its rising edge updates a latch |
| mainEnIn | input | 1 | Hardware enable for the main section |
| auxEnIn | input | 1 | Hardware enable for the auxiliary section |
| latchData | output | 64 | Four 16-bit latch payloads, latch i at [16*i +: 16] |
| latchStrobe | output | 4 | One-cycle update pulse, one bit per latch |
| mainEnOut | output | 1 | Synchronized main section enable |
| auxEnOut | output | 1 | Synchronized auxiliary section enable |

## Verification
The assertions assume that serData is stable for several system clocks around each serial clock rise, so the data and the clock leave their synchronizers in step. They also assume that a serial clock rise and a load rise never come out of the synchronizers in the same cycle. The stimulus holds each serial level for four system clocks or more, changes data only while the serial clock is low, and separates every load pulse from the serial clock activity by several cycles. The bench sweeps every address against many arithmetic payload patterns and keeps a model of all four latches. It also covers words longer than 18 bits and serial clocking while the load strobe is held high.

// File: rtl/slb_pkg.sv
package slb_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/slb_sync.sv
module slb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[s] <= '0;
          else        stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[s] <= '0;
          else        stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/slb_ctrl.sv
module slb_ctrl
  import slb_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclkSync,
  input  logic         loadSync,
  output ctrlStrobes_t strobes
);
  logic sclkPrev;
  logic loadPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkPrev <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkSync;
      loadPrev <= loadSync;
    end
  end

  always_comb begin
    strobes.shiftEn = sclkSync & ~sclkPrev;
    strobes.loadEn  = loadSync & ~loadPrev;
  end
endmodule

// File: rtl/slb_datapath.sv
module slb_datapath
  import slb_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int ADDR_W    = 2,
  parameter int NUM_LATCH = 4,
  parameter int PAY_W     = WORD_W - ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctrlStrobes_t               strobes,
  input  logic                       dataBit,
  output logic [NUM_LATCH*PAY_W-1:0] latchFlat,
  output logic [NUM_LATCH-1:0]       latchStrobe
);
  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] selAddr;
  logic [PAY_W-1:0]  payload;
  logic [PAY_W-1:0]  latchQ [NUM_LATCH];

  assign selAddr = shiftReg[ADDR_W-1:0];
  assign payload = shiftReg[WORD_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                shiftReg <= '0;
    else if (strobes.shiftEn)  shiftReg <= {shiftReg[WORD_W-2:0], dataBit};
  end

  // a_r2_shift_lsb: a serial rise places the sampled bit in bit 0
  a_r2_shift_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.shiftEn |=> shiftReg[0] == $past(dataBit));

  generate
    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
      logic hit;
      assign hit = strobes.loadEn && (selAddr == ADDR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          latchQ[i]      <= '0;
          latchStrobe[i] <= 1'b0;
        end else begin
          latchStrobe[i] <= hit;
          if (hit) latchQ[i] <= payload;
        end
      end

      assign latchFlat[i*PAY_W +: PAY_W] = latchQ[i];

      // a_r4_hold_unless_strobed: a latch changes only in the cycle its strobe shows
      a_r4_hold_unless_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        !latchStrobe[i] |-> $stable(latchQ[i]));
    end
  endgenerate

  // a_r5_single_strobe: never more than one latch updated at once
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(latchStrobe));

  // a_r6_strobe_needs_load: a strobe follows a load edge one cycle earlier
  a_r6_strobe_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    (latchStrobe != '0) |-> $past(strobes.loadEn));
endmodule

// File: rtl/serial_latch_bank.sv
module serial_latch_bank
  import slb_pkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_LATCH  = 1 << ADDR_W,
  localparam int PAY_W      = WORD_W - ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       serClk,
  input  logic                       serData,
  input  logic                       serLoad,
  input  logic                       mainEnIn,
  input  logic                       auxEnIn,
  output logic [NUM_LATCH*PAY_W-1:0] latchData,
  output logic [NUM_LATCH-1:0]       latchStrobe,
  output logic                       mainEnOut,
  output logic                       auxEnOut
);
  logic [4:0]   syncVec;
  ctrlStrobes_t strobes;

  slb_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({serClk, serData, serLoad, mainEnIn, auxEnIn}),
    .syncOut (syncVec)
  );

  slb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclkSync (syncVec[4]),
    .loadSync (syncVec[2]),
    .strobes  (strobes)
  );

  slb_datapath #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .NUM_LATCH (NUM_LATCH),
    .PAY_W     (PAY_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .dataBit     (syncVec[3]),
    .latchFlat   (latchData),
    .latchStrobe (latchStrobe)
  );

  assign mainEnOut = syncVec[1];
  assign auxEnOut  = syncVec[0];
endmodule

// File: tb/sim_serial_latch_bank.sv
module sim_serial_latch_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic mainEnIn = 1'b0, auxEnIn = 1'b0;
  logic [63:0] latchData;
  logic [3:0]  latchStrobe;
  logic mainEnOut, auxEnOut;

  int checks = 0;
  int fails = 0;
  int strobeCnt [4];
  logic [15:0] model [4];
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_latch_bank u0 (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .mainEnIn(mainEnIn), .auxEnIn(auxEnIn),
    .latchData(latchData), .latchStrobe(latchStrobe),
    .mainEnOut(mainEnOut), .auxEnOut(auxEnOut)
  );

  always @(negedge clk)
    for (int i = 0; i < 4; i++) if (latchStrobe[i]) strobeCnt[i]++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    waitCyc(2);
    serClk = 1'b1;
    waitCyc(4);
    serClk = 1'b0;
    waitCyc(4);
  endtask

  task automatic sendWord(input logic [17:0] w);
    for (int k = 17; k >= 0; k--) sendBit(w[k]);
  endtask

  task automatic clearCnt();
    for (int i = 0; i < 4; i++) strobeCnt[i] = 0;
  endtask

  task automatic pulseLoad();
    serLoad = 1'b1;
    waitCyc(6);
    serLoad = 1'b0;
    waitCyc(6);
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < 4; i++) check(req, {16'h0, latchData[i*16 +: 16]}, {16'h0, model[i]});
  endtask

  task automatic checkStrobes(input string req, input int target);
    for (int i = 0; i < 4; i++) check(req, strobeCnt[i], (i == target) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 16'h0;
    waitCyc(3);
    // R1: reset state
    check("R1 latches", {31'h0, latchData == 64'h0}, 32'h1);
    check("R1 strobes", {28'h0, latchStrobe}, 32'h0);
    rst_n = 1'b1;
    waitCyc(3);
    check("R1 after release", {31'h0, latchData == 64'h0}, 32'h1);
    // R1: shift register cleared -> a bare load into latch 0 stores zero
    clearCnt();
    pulseLoad();
    checkAll("R1 shift reg zero");
    checkStrobes("R1 load latch0", 0);

    // R3 R4 R5: sweep every address against arithmetic payloads
    for (int k = 0; k < 10; k++) begin
      for (int a = 0; a < 4; a++) begin
        logic [15:0] p;
        p = 16'((k * 16'h1357 + a * 16'h2469) ^ (16'h1 << ((k + a) % 16)));
        clearCnt();
        sendWord({p, 2'(a)});
        pulseLoad();
        model[a] = p;
        checkAll("R3 R4 sweep");
        checkStrobes("R5 strobe", a);
      end
    end

    // R2: extra leading bits fall off; only last 18 kept, MSB first
    clearCnt();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    sendWord({16'h8001, 2'd2});
    pulseLoad();
    model[2] = 16'h8001;
    checkAll("R2 overlength word");
    checkStrobes("R2 strobe", 2);

    // R6: hold load high, shift a new word, no update until next rise
    clearCnt();
    sendWord({16'hC3A5, 2'd1});
    serLoad = 1'b1;
    waitCyc(6);
    model[1] = 16'hC3A5;
    sendWord({16'h5A5A, 2'd3});
    waitCyc(6);
    checkAll("R6 no update while held");
    checkStrobes("R6 single strobe held", 1);
    clearCnt();
    serLoad = 1'b0;
    waitCyc(6);
    checkAll("R6 no update on fall");
    check("R6 no strobe on fall", strobeCnt[3], 0);
    pulseLoad();
    model[3] = 16'h5A5A;
    checkAll("R6 shifted while high then loaded");
    checkStrobes("R6 strobe", 3);

    // R7: enables follow independently
    mainEnIn = 1'b1;
    @(posedge clk); #1;
    check("R7 main not yet", {31'h0, mainEnOut}, 32'h0);
    @(posedge clk); #1;
    check("R7 main after two", {31'h0, mainEnOut}, 32'h1);
    check("R7 aux independent", {31'h0, auxEnOut}, 32'h0);
    auxEnIn = 1'b1;
    mainEnIn = 1'b0;
    waitCyc(2);
    check("R7 aux high", {31'h0, auxEnOut}, 32'h1);
    check("R7 main low", {31'h0, mainEnOut}, 32'h0);
    auxEnIn = 1'b0;
    waitCyc(2);
    check("R7 aux low", {31'h0, auxEnOut}, 32'h0);
    checkAll("R4 enables leave latches");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule